// File: doc/BRIEF.md
# Clock-Stop Duty-Cycle Throttle Controller

This block produces an active-low clock-stop signal for a processor. Whenever throttling is in force, it pulls the signal low for a programmable number of clocks at the start of every 1024-clock period and holds it high for the rest of that period. This lowers the processor's effective run time by a fixed fraction.

Two sources can request throttling. Software sets an enable bit and a 3-bit duty code. A thermal override input needs no enable; its duty comes from a second 3-bit field that accepts exactly one write after reset. Either source acts only while the power-state input reports the full-run state. When both sources are active, the thermal duty is used. A new duty selection is applied at the next period boundary, so a period that has started always runs to its end.

A small write port loads the two fields. A read-back word shows both fields, the enable bit and a flag that records whether the thermal field has been written. The synchronous reset input plays the role of the platform bus reset.

Top module: `clkstop_throttle`

## Requirements
- R1: After reset `stop_n` is 1 and `rd_data` reads 8'h00: software duty code 000, software enable 0, thermal code 000, lock flag 0.
- R2: A duty code gives the number of low clocks per period as follows: 001→896, 010→768, 011→640, 100→512, 101→384, 110→256, 111→128. Code 000 gives 512 for the software field and also for the thermal field, where 000 is otherwise unused.
- R3: A throttle period lasts exactly 1024 clocks. `stop_n` is low for the selected number of clocks at the start of each period and high for the remaining clocks. The first period starts on the clock edge where throttling becomes active.
- R4: Software throttling runs only when the software enable bit is 1 and `full_run` is 1. In all other cases, and when `thrm_ovr` is 0, `stop_n` stays high.
- R5: Thermal throttling runs whenever `thrm_ovr` is 1 and `full_run` is 1. It does not depend on the software enable bit.
- R6: When `thrm_ovr` is 1 and software throttling is also enabled, the thermal duty code decides the low time.
- R7: The thermal field accepts only its first write after reset, and that write sets the lock flag. Later thermal writes change neither the field nor the flag until reset.
- R8: A change to the selected duty, whether from a register write or from a change of source, takes effect only at the next period boundary.
- R9: When throttling stops (`full_run` falls, or no source is active), `stop_n` is 1 from the next clock onward. The next throttle run starts a new period from its beginning.
- R10: Write layout: `wr_sel`=0 writes software `{enable, code}` from `wr_data[3]` and `wr_data[2:0]`. `wr_sel`=1 writes the thermal code from `wr_data[2:0]`. Read layout: `rd_data` = {lock, thermal code[2:0], software enable, software code[2:0]}, with the lock flag in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is 1024 of its cycles |
| rst | input | 1 | Synchronous active-high reset (bus reset) |
| full_run | input | 1 | Power state is full-run; throttling is allowed only while it is 1 |
| thrm_ovr | input | 1 | Thermal override request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 software field, 1 thermal field |
| wr_data | input | 4 | Write data, layout as in R10 |
| rd_data | output | 8 | Read-back word, layout as in R10 |
| stop_n | output | 1 | Active-low clock-stop output |

## Verification
A duty write and a running throttle period can land in the same cycle. The bench provokes this by writing a new software code 100 clocks into a 50% period. It then checks that the current period still gives 512 low clocks and that the following period gives the new count. A second case raises the thermal request and the software enable on the same edge, with different codes in the two fields. The bench checks that the very first period already takes the thermal count and not the software count.

// File: rtl/thr_pkg.sv
package thr_pkg;

  localparam int DEF_CNT_W  = 10;
  localparam int DEF_CODE_W = 3;

  typedef enum logic {
    WSEL_SOFTWARE = 1'b0,
    WSEL_THERMAL  = 1'b1
  } wsel_e;

  // Low clocks per period for a duty code: code 0 means half the period,
  // otherwise (2^code_w - code) slices of period / 2^code_w clocks.
  function automatic int duty_clocks(int code, int code_w, int cnt_w);
    int period;
    int slice;
    period = 1 << cnt_w;
    slice  = period >> code_w;
    if (code == 0) return period / 2;
    return ((1 << code_w) - code) * slice;
  endfunction

endpackage

// File: rtl/thr_regs.sv
module thr_regs #(
  parameter int CODE_W = thr_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CODE_W:0]   wr_data,
  output logic              sw_en,
  output logic [CODE_W-1:0] sw_code,
  output logic [CODE_W-1:0] th_code,
  output logic              th_locked
);
  import thr_pkg::*;

  logic wr_thermal;
  logic wr_software;

  assign wr_thermal  = wr_en && (wr_sel == 1'(WSEL_THERMAL));
  assign wr_software = wr_en && (wr_sel == 1'(WSEL_SOFTWARE));

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en     <= 1'b0;
      sw_code   <= '0;
      th_code   <= '0;
      th_locked <= 1'b0;
    end else begin
      if (wr_software) begin
        sw_en   <= wr_data[CODE_W];
        sw_code <= wr_data[CODE_W-1:0];
      end
      if (wr_thermal && !th_locked) begin
        th_code   <= wr_data[CODE_W-1:0];
        th_locked <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/thr_select.sv
module thr_select #(
  parameter int CNT_W  = thr_pkg::DEF_CNT_W,
  parameter int CODE_W = thr_pkg::DEF_CODE_W,
  localparam int LIM_W = CNT_W + 1
) (
  input  logic              full_run,
  input  logic              thrm_ovr,
  input  logic              sw_en,
  input  logic [CODE_W-1:0] sw_code,
  input  logic [CODE_W-1:0] th_code,
  output logic              active,
  output logic              use_thermal,
  output logic [LIM_W-1:0]  sel_lim
);
  import thr_pkg::*;

  logic [CODE_W-1:0] code_pick;

  assign use_thermal = thrm_ovr;
  assign active      = full_run && (thrm_ovr || sw_en);
  assign code_pick   = use_thermal ? th_code : sw_code;
  assign sel_lim     = LIM_W'(duty_clocks(int'(code_pick), CODE_W, CNT_W));

endmodule

// File: rtl/thr_period.sv
module thr_period #(
  parameter int CNT_W  = thr_pkg::DEF_CNT_W,
  parameter int CODE_W = thr_pkg::DEF_CODE_W,
  localparam int LIM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [LIM_W-1:0] sel_lim,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt,
  output logic [LIM_W-1:0] lim_q,
  output logic             wrap,
  output logic             stop_n
);
  import thr_pkg::*;

  localparam logic [LIM_W-1:0] RESET_LIM = LIM_W'(duty_clocks(0, CODE_W, CNT_W));

  logic in_stop;

  assign wrap    = run_q && (cnt == {CNT_W{1'b1}});
  assign in_stop = run_q && ({1'b0, cnt} < lim_q);
  assign stop_n  = !in_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt   <= '0;
      lim_q <= RESET_LIM;
    end else if (!active) begin
      run_q <= 1'b0;
      cnt   <= '0;
      lim_q <= sel_lim;
    end else begin
      run_q <= 1'b1;
      if (run_q) cnt <= cnt + CNT_W'(1);
      if (!run_q || wrap) lim_q <= sel_lim;
    end
  end

endmodule

// File: rtl/clkstop_throttle.sv
module clkstop_throttle #(
  parameter int CNT_W  = thr_pkg::DEF_CNT_W,
  parameter int CODE_W = thr_pkg::DEF_CODE_W,
  localparam int LIM_W = CNT_W + 1,
  localparam int RD_W  = 2 * CODE_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            full_run,
  input  logic            thrm_ovr,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [CODE_W:0] wr_data,
  output logic [RD_W-1:0] rd_data,
  output logic            stop_n
);

  logic              sw_en;
  logic [CODE_W-1:0] sw_code;
  logic [CODE_W-1:0] th_code;
  logic              th_locked;
  logic              active;
  logic              use_thermal;
  logic [LIM_W-1:0]  sel_lim;
  logic              run_q;
  logic [CNT_W-1:0]  cnt;
  logic [LIM_W-1:0]  lim_q;
  logic              wrap;

  thr_regs #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sw_en     (sw_en),
    .sw_code   (sw_code),
    .th_code   (th_code),
    .th_locked (th_locked)
  );

  thr_select #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_sel (
    .full_run    (full_run),
    .thrm_ovr    (thrm_ovr),
    .sw_en       (sw_en),
    .sw_code     (sw_code),
    .th_code     (th_code),
    .active      (active),
    .use_thermal (use_thermal),
    .sel_lim     (sel_lim)
  );

  thr_period #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_period (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .sel_lim (sel_lim),
    .run_q   (run_q),
    .cnt     (cnt),
    .lim_q   (lim_q),
    .wrap    (wrap),
    .stop_n  (stop_n)
  );

  assign rd_data = {th_locked, th_code, sw_en, sw_code};

endmodule

// File: rtl/clkstop_throttle_chk.sv
module clkstop_throttle_chk #(
  parameter int CNT_W  = 10,
  parameter int CODE_W = 3,
  localparam int LIM_W = CNT_W + 1,
  localparam int RD_W  = 2 * CODE_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             full_run,
  input logic             thrm_ovr,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [RD_W-1:0]  rd_data,
  input logic             stop_n,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt,
  input logic [LIM_W-1:0] lim_q,
  input logic             wrap
);

  logic              lock_bit;
  logic [CODE_W-1:0] th_field;
  logic              sw_en_bit;

  assign lock_bit  = rd_data[RD_W-1];
  assign th_field  = rd_data[RD_W-2 -: CODE_W];
  assign sw_en_bit = rd_data[CODE_W];

  // R3: a run opens a period at count zero with the output already low
  p_period_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (cnt == '0 && !stop_n));

  // R3: the last clock of a period is followed by count zero
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  // R4: no request from either source keeps the output high
  p_no_request_r4: assert property (@(posedge clk) disable iff (rst)
    (!thrm_ovr && !sw_en_bit) |=> stop_n);

  // R9: leaving full-run releases the output by the next clock
  p_leave_run_r9: assert property (@(posedge clk) disable iff (rst)
    !full_run |=> stop_n);

  // R7: a thermal write always leaves the field locked
  p_lock_set_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> lock_bit);

  // R7: once locked, flag and thermal field never change
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
    lock_bit |=> (lock_bit && $stable(th_field)));

  // R8: inside a running period the applied limit is frozen
  p_limit_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> (!run_q || $stable(lim_q)));

endmodule

bind clkstop_throttle clkstop_throttle_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .full_run (full_run),
  .thrm_ovr (thrm_ovr),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .rd_data  (rd_data),
  .stop_n   (stop_n),
  .run_q    (run_q),
  .cnt      (cnt),
  .lim_q    (lim_q),
  .wrap     (wrap)
);

// File: tb/tb_clkstop_throttle.sv
`timescale 1ns/1ps
module tb_clkstop_throttle;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       full_run = 1'b0;
  logic       thrm_ovr = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [7:0] rd_data;
  logic       stop_n;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  clkstop_throttle dut (
    .clk      (clk),
    .rst      (rst),
    .full_run (full_run),
    .thrm_ovr (thrm_ovr),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .stop_n   (stop_n)
  );

  // {thermal source, code[2:0], expected low clocks[10:0]} for R2, R3, R5
  localparam logic [14:0] VEC [16] = '{
    {1'b0, 3'd0, 11'd512}, {1'b0, 3'd1, 11'd896},
    {1'b0, 3'd2, 11'd768}, {1'b0, 3'd3, 11'd640},
    {1'b0, 3'd4, 11'd512}, {1'b0, 3'd5, 11'd384},
    {1'b0, 3'd6, 11'd256}, {1'b0, 3'd7, 11'd128},
    {1'b1, 3'd0, 11'd512}, {1'b1, 3'd1, 11'd896},
    {1'b1, 3'd2, 11'd768}, {1'b1, 3'd3, 11'd640},
    {1'b1, 3'd4, 11'd512}, {1'b1, 3'd5, 11'd384},
    {1'b1, 3'd6, 11'd256}, {1'b1, 3'd7, 11'd128}
  };

  task automatic check(input int act, input int exp, input string req);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; full_run = 1'b0; thrm_ovr = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_reg(input logic sel, input logic [3:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Called at a negedge just after the run inputs were driven;
  // counts low samples over the next 1024 clocks.
  task automatic count_period(output int lows);
    lows = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (!stop_n) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int lows;
    int highs;

    // R1: reset state
    do_reset();
    @(negedge clk);
    check(int'(stop_n), 1, "R1 stop_n after reset");
    check(int'(rd_data), 8'h00, "R1 rd_data after reset");

    // R2 / R3 / R5: duty table for both sources
    for (int v = 0; v < 16; v++) begin
      do_reset();
      if (VEC[v][14]) begin
        write_reg(1'b1, {1'b0, VEC[v][13:11]});
        thrm_ovr = 1'b1;
      end else begin
        write_reg(1'b0, {1'b1, VEC[v][13:11]});
      end
      full_run = 1'b1;
      count_period(lows);
      check(lows, int'(VEC[v][10:0]), VEC[v][14] ? "R5 R2 thermal duty" : "R2 R3 software duty");
    end

    // R3: second period repeats the same count, period length 1024
    do_reset();
    write_reg(1'b0, 4'b1110);
    full_run = 1'b1;
    count_period(lows);
    count_period(lows);
    check(lows, 256, "R3 second period count");

    // R4: enable set but not in full-run
    do_reset();
    write_reg(1'b0, 4'b1001);
    highs = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (stop_n) highs++; end
    check(highs, 64, "R4 enabled outside full-run");
    // R4: full-run but enable clear
    write_reg(1'b0, 4'b0001);
    full_run = 1'b1;
    highs = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (stop_n) highs++; end
    check(highs, 64, "R4 full-run with enable clear");

    // R6: both sources from the same edge, thermal code wins
    do_reset();
    write_reg(1'b0, 4'b1111);
    write_reg(1'b1, 4'b0001);
    thrm_ovr = 1'b1; full_run = 1'b1;
    count_period(lows);
    check(lows, 896, "R6 thermal precedence");

    // R7 / R10: write-once thermal field and read layout
    do_reset();
    write_reg(1'b0, 4'b1110);
    check(int'(rd_data), 8'h0E, "R10 software read layout");
    write_reg(1'b1, 4'b0010);
    check(int'(rd_data), 8'hAE, "R10 R7 thermal write and lock");
    write_reg(1'b1, 4'b0101);
    check(int'(rd_data), 8'hAE, "R7 second thermal write ignored");
    thrm_ovr = 1'b1; full_run = 1'b1;
    count_period(lows);
    check(lows, 768, "R7 locked thermal code in effect");
    do_reset();
    @(negedge clk);
    check(int'(rd_data), 8'h00, "R7 reset clears lock");
    write_reg(1'b1, 4'b0101);
    check(int'(rd_data), 8'hD0, "R7 write accepted after reset");

    // R8: duty write mid-period deferred to the boundary
    do_reset();
    write_reg(1'b0, 4'b1100);
    full_run = 1'b1;
    lows = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (!stop_n) lows++;
      if (i == 100) begin
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1111;
      end else begin
        wr_en = 1'b0;
      end
    end
    check(lows, 512, "R8 current period keeps old duty");
    count_period(lows);
    check(lows, 128, "R8 next period uses new duty");

    // R8: source change mid-period also deferred
    do_reset();
    write_reg(1'b0, 4'b1111);
    write_reg(1'b1, 4'b0001);
    full_run = 1'b1;
    lows = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (!stop_n) lows++;
      if (i == 50) thrm_ovr = 1'b1;
    end
    check(lows, 128, "R8 source change deferred");
    count_period(lows);
    check(lows, 896, "R8 thermal duty after boundary");

    // R9: drop out of full-run in the low phase, then restart
    do_reset();
    write_reg(1'b0, 4'b1100);
    full_run = 1'b1;
    repeat (10) @(negedge clk);
    check(int'(stop_n), 0, "R9 low during active phase");
    full_run = 1'b0;
    @(negedge clk);
    check(int'(stop_n), 1, "R9 released next clock");
    repeat (5) @(negedge clk);
    full_run = 1'b1;
    count_period(lows);
    check(lows, 512, "R9 restart from period start");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule